// File: doc/BRIEF.md
# SCSI Initiator DMA Receive Handshake

This block runs the initiator side of the REQ/ACK byte handshake when a SCSI target sends data and the host collects it by DMA. A start strobe arms the block. It waits for the target to raise REQ, captures the data bus into a holding register and answers with ACK. It then waits for REQ to fall and releases ACK. The DMA request (DRQ) to the host rises only when this whole exchange has ended. A host DMA read of the held byte lowers DRQ. While DMA mode is on, that read also arms the handshake for the next byte, so a burst runs as a chain of read-triggered handshakes.

The block also tracks whether the bus phase (message, control/data, input/output lines) equals the phase the host expects. It keeps a DMA-mode flag and an end-of-transfer flag. If BSY falls or the phase stops matching while DMA mode is on, the block leaves DMA mode by itself, flags the end of the transfer and withdraws DRQ. REQ, BSY and the phase lines pass through a synchronizer, two stages by default, before any logic uses them. A soft reset returns the handshake and the flags to their idle values.

Top module: `scsi_dma_rx`

## Requirements
- R1: After `start_rx`, a `bus_req` that stays high makes `bus_ack` rise in the third clock after REQ is first sampled. The bus byte present at that edge then appears on `rx_data` and stays there.
- R2: While `bus_ack` is high it stays high until the synchronized REQ is low, and then it falls in the third clock after REQ drops. The handshake is then idle, and a later REQ with no new start or DMA read gets no ACK.
- R3: `drq` rises in the same cycle that `bus_ack` falls at the end of a handshake. It is never raised while a latched byte's ACK is still high.
- R4: `phase_match` is high when the synchronized {MSG, C/D, I/O} lines (bit 2, bit 1, bit 0) equal the expected phase. The expected phase is taken from `tcmd_phase` on `tcmd_wr`. A new expected phase is reflected one clock after the write, and a change on the bus lines three clocks after it.
- R5: When `dma_mode` is high and the synchronized BSY is low or `phase_match` is low, the next edge clears `dma_mode`, sets `end_of_dma` and clears `drq`.
- R6: A `dma_rd` pulse clears `drq` at the next edge. It starts the next handshake only when `dma_mode` is high. With DMA mode off, a following REQ gets no ACK.
- R7: `mode_wr` loads `dma_mode` from `mode_val`. Loading a 1 also clears `end_of_dma`.
- R8: `soft_rst` makes `bus_ack`, `drq`, `end_of_dma` and `dma_mode` low at the next edge and returns the handshake to idle, so a held REQ then gets no ACK.
- R9: After `rst`, `bus_ack`, `drq`, `end_of_dma` and `dma_mode` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Soft reset of handshake and flags |
| bus_req | input | 1 | Target REQ, active high, asynchronous |
| bus_bsy | input | 1 | BSY, active high, asynchronous |
| bus_msg | input | 1 | MSG phase line |
| bus_cd | input | 1 | C/D phase line |
| bus_io | input | 1 | I/O phase line |
| bus_data | input | DATA_W | Bus data byte |
| start_rx | input | 1 | Start-receive strobe |
| mode_wr | input | 1 | Load strobe for the DMA-mode flag |
| mode_val | input | 1 | DMA-mode value to load |
| tcmd_wr | input | 1 | Load strobe for the expected phase |
| tcmd_phase | input | 3 | Expected {MSG, C/D, I/O} |
| dma_rd | input | 1 | Host DMA read of the held byte |
| bus_ack | output | 1 | Initiator ACK, active high |
| drq | output | 1 | DMA request to the host |
| rx_data | output | DATA_W | Held received byte |
| dma_mode | output | 1 | DMA mode active |
| end_of_dma | output | 1 | Transfer ended by BSY loss or phase mismatch |
| phase_match | output | 1 | Bus phase equals expected phase |

## Verification
The assertions assume that `bus_data` is stable on the edge where ACK is raised, and that `dma_rd` is pulsed only while `drq` is high. The target model in the bench sets the data together with REQ and holds it until ACK is seen. The host side of the bench issues reads only after it has seen DRQ. Phase and BSY changes are made while REQ is idle, so a termination never races a REQ edge inside the synchronizer.

// File: rtl/scsi_rx_pkg.sv
package scsi_rx_pkg;
  localparam int PHASE_W = 3;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_WAIT_HI = 2'd1,
    HS_WAIT_LO = 2'd2
  } hs_state_t;
endpackage

// File: rtl/scsi_rx_sync.sv
module scsi_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scsi_rx_phase.sv
module scsi_rx_phase
  import scsi_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic [PHASE_W-1:0] phase_s,
  input  logic               bsy_s,
  input  logic               tcmd_wr,
  input  logic [PHASE_W-1:0] tcmd_phase,
  input  logic               mode_wr,
  input  logic               mode_val,
  output logic               phase_match,
  output logic               dma_mode,
  output logic               end_of_dma,
  output logic               term
);
  logic [PHASE_W-1:0] exp_q;
  logic [PHASE_W-1:0] exp_next;

  assign exp_next = tcmd_wr ? tcmd_phase : exp_q;

  // expected phase and registered compare
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q       <= '0;
      phase_match <= 1'b0;
    end else begin
      exp_q       <= exp_next;
      phase_match <= (phase_s == exp_next);
    end
  end

  assign term = dma_mode && (!bsy_s || !phase_match);

  // mode / end-of-transfer flags; termination wins over a host load
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      dma_mode   <= 1'b0;
      end_of_dma <= 1'b0;
    end else begin
      if (mode_wr) begin
        dma_mode <= mode_val;
        if (mode_val) end_of_dma <= 1'b0;
      end
      if (term) begin
        dma_mode   <= 1'b0;
        end_of_dma <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scsi_rx_hs.sv
module scsi_rx_hs
  import scsi_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              req_s,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              start_rx,
  input  logic              dma_rd,
  input  logic              dma_mode,
  input  logic              term,
  output logic              bus_ack,
  output logic              drq,
  output logic [DATA_W-1:0] rx_data
);
  hs_state_t st;
  logic      hs_done;
  logic      drq_nxt;

  assign hs_done = (st == HS_WAIT_LO) && !req_s;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st      <= HS_IDLE;
      bus_ack <= 1'b0;
    end else begin
      case (st)
        HS_IDLE: begin
          if (start_rx || (dma_rd && dma_mode)) st <= HS_WAIT_HI;
        end
        HS_WAIT_HI: begin
          if (req_s) begin
            bus_ack <= 1'b1;
            st      <= HS_WAIT_LO;
          end
        end
        HS_WAIT_LO: begin
          if (!req_s) begin
            bus_ack <= 1'b0;
            st      <= HS_IDLE;
          end
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rx_data <= '0;
    else if (st == HS_WAIT_HI && req_s) rx_data <= bus_data;
  end

  // later terms take priority: completion < host read < termination
  always_comb begin
    drq_nxt = drq;
    if (hs_done) drq_nxt = 1'b1;
    if (dma_rd)  drq_nxt = 1'b0;
    if (term)    drq_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) drq <= 1'b0;
    else                 drq <= drq_nxt;
  end
endmodule

// File: rtl/scsi_dma_rx.sv
module scsi_dma_rx
  import scsi_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               soft_rst,
  input  logic               bus_req,
  input  logic               bus_bsy,
  input  logic               bus_msg,
  input  logic               bus_cd,
  input  logic               bus_io,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               start_rx,
  input  logic               mode_wr,
  input  logic               mode_val,
  input  logic               tcmd_wr,
  input  logic [PHASE_W-1:0] tcmd_phase,
  input  logic               dma_rd,
  output logic               bus_ack,
  output logic               drq,
  output logic [DATA_W-1:0]  rx_data,
  output logic               dma_mode,
  output logic               end_of_dma,
  output logic               phase_match
);
  localparam int CTL_W = PHASE_W + 2;

  logic [CTL_W-1:0]   ctl_s;
  logic               req_s;
  logic               bsy_s;
  logic [PHASE_W-1:0] phase_s;
  logic               term;

  scsi_rx_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bus_req, bus_bsy, bus_msg, bus_cd, bus_io}),
    .q   (ctl_s)
  );

  assign req_s   = ctl_s[CTL_W-1];
  assign bsy_s   = ctl_s[CTL_W-2];
  assign phase_s = ctl_s[PHASE_W-1:0];

  scsi_rx_phase u_phase (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .phase_s     (phase_s),
    .bsy_s       (bsy_s),
    .tcmd_wr     (tcmd_wr),
    .tcmd_phase  (tcmd_phase),
    .mode_wr     (mode_wr),
    .mode_val    (mode_val),
    .phase_match (phase_match),
    .dma_mode    (dma_mode),
    .end_of_dma  (end_of_dma),
    .term        (term)
  );

  scsi_rx_hs #(.DATA_W(DATA_W)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .req_s    (req_s),
    .bus_data (bus_data),
    .start_rx (start_rx),
    .dma_rd   (dma_rd),
    .dma_mode (dma_mode),
    .term     (term),
    .bus_ack  (bus_ack),
    .drq      (drq),
    .rx_data  (rx_data)
  );
endmodule

// File: rtl/scsi_dma_rx_chk.sv
module scsi_dma_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [DATA_W-1:0] bus_data,
  input logic              dma_rd,
  input logic              req_s,
  input logic              bsy_s,
  input logic              bus_ack,
  input logic              drq,
  input logic [DATA_W-1:0] rx_data,
  input logic              dma_mode,
  input logic              end_of_dma,
  input logic              phase_match
);
  a_r1_byte_latched: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(bus_ack) |-> rx_data == $past(bus_data));

  a_r2_ack_held: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (bus_ack && req_s) |=> bus_ack);

  a_r3_drq_after_cycle: assert property (@(posedge clk) disable iff (rst || soft_rst)
    $rose(drq) |-> $fell(bus_ack));

  a_r5_bsy_loss: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (dma_mode && !bsy_s) |=> (!dma_mode && end_of_dma && !drq));

  a_r5_phase_loss: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (dma_mode && !phase_match) |=> (!dma_mode && end_of_dma && !drq));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (rst || soft_rst)
    dma_rd |=> !drq);

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!bus_ack && !drq && !end_of_dma && !dma_mode));
endmodule

bind scsi_dma_rx scsi_dma_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .soft_rst    (soft_rst),
  .bus_data    (bus_data),
  .dma_rd      (dma_rd),
  .req_s       (req_s),
  .bsy_s       (bsy_s),
  .bus_ack     (bus_ack),
  .drq         (drq),
  .rx_data     (rx_data),
  .dma_mode    (dma_mode),
  .end_of_dma  (end_of_dma),
  .phase_match (phase_match)
);

// File: tb/test_scsi_dma_rx.sv
`timescale 1ns/1ps
module test_scsi_dma_rx;
  logic       clk = 1'b0;
  logic       rst, soft_rst;
  logic       bus_req, bus_bsy, bus_msg, bus_cd, bus_io;
  logic [7:0] bus_data;
  logic       start_rx, mode_wr, mode_val, tcmd_wr, dma_rd;
  logic [2:0] tcmd_phase;
  logic       bus_ack, drq, dma_mode, end_of_dma, phase_match;
  logic [7:0] rx_data;

  int   vectors = 0;
  int   fails   = 0;
  bit   done    = 1'b0;
  bit   mon_auto = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  scsi_dma_rx i_scsi_dma_rx (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .bus_req(bus_req), .bus_bsy(bus_bsy), .bus_msg(bus_msg), .bus_cd(bus_cd), .bus_io(bus_io),
    .bus_data(bus_data), .start_rx(start_rx), .mode_wr(mode_wr), .mode_val(mode_val),
    .tcmd_wr(tcmd_wr), .tcmd_phase(tcmd_phase), .dma_rd(dma_rd),
    .bus_ack(bus_ack), .drq(drq), .rx_data(rx_data), .dma_mode(dma_mode),
    .end_of_dma(end_of_dma), .phase_match(phase_match)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_rx = 1'b1; tick(1); start_rx = 1'b0;
  endtask

  task automatic write_mode(input logic v);
    mode_wr = 1'b1; mode_val = v; tick(1); mode_wr = 1'b0;
  endtask

  // target side of one byte; optionally queue it for the scoreboard
  task automatic send_byte(input logic [7:0] b, input bit lat, input bit push);
    int n;
    if (push) exp_q.push_back(b);
    bus_data = b; bus_req = 1'b1; n = 0;
    do begin tick(1); n++; end while (!bus_ack && n < 60);
    chk(bus_ack, "R1", bus_ack, 1);
    if (lat) chk(n == 3, "R1", n, 3);
    chk(!drq, "R3", drq, 0);
    if (!push) chk(rx_data == b, "R1", rx_data, b);
    bus_req = 1'b0; n = 0;
    do begin tick(1); n++; end while (bus_ack && n < 60);
    chk(!bus_ack, "R2", bus_ack, 0);
    if (lat) chk(n == 3, "R2", n, 3);
    chk(drq, "R3", drq, 1);
  endtask

  // monitor: acts as the DMA host, pops and compares each delivered byte
  initial begin
    forever begin
      @(negedge clk);
      if (mon_auto && drq) begin : mon_take
        logic [7:0] e;
        if (exp_q.size() == 0) chk(1'b0, "R1", rx_data, 0);
        else begin
          e = exp_q.pop_front();
          chk(rx_data == e, "R1", rx_data, e);
        end
        dma_rd = 1'b1;
        @(negedge clk);
        dma_rd = 1'b0;
        chk(!drq, "R6", drq, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; soft_rst = 1'b0; bus_req = 1'b0; bus_bsy = 1'b1;
    bus_msg = 1'b0; bus_cd = 1'b0; bus_io = 1'b0; bus_data = 8'h00;
    start_rx = 1'b0; mode_wr = 1'b0; mode_val = 1'b0; tcmd_wr = 1'b0;
    tcmd_phase = 3'b000; dma_rd = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R9 reset state
    chk(!bus_ack, "R9", bus_ack, 0);
    chk(!drq, "R9", drq, 0);
    chk(!end_of_dma, "R9", end_of_dma, 0);
    chk(!dma_mode, "R9", dma_mode, 0);
    tick(3);
    chk(phase_match, "R4", phase_match, 1);

    // R4 expected phase = data-in (I/O = bit 0)
    tcmd_wr = 1'b1; tcmd_phase = 3'b001; tick(1); tcmd_wr = 1'b0;
    chk(!phase_match, "R4", phase_match, 0);
    bus_io = 1'b1; tick(2);
    chk(!phase_match, "R4", phase_match, 0);
    tick(1);
    chk(phase_match, "R4", phase_match, 1);

    // single byte, DMA mode off
    pulse_start();
    send_byte(8'hA5, 1'b1, 1'b0);
    bus_req = 1'b1; tick(8);
    chk(!bus_ack, "R2", bus_ack, 0);
    bus_req = 1'b0; tick(4);
    dma_rd = 1'b1; tick(1); dma_rd = 1'b0;
    chk(!drq, "R6", drq, 0);
    bus_req = 1'b1; tick(8);
    chk(!bus_ack, "R6", bus_ack, 0);
    bus_req = 1'b0; tick(4);

    // R7 enter DMA mode, then a scoreboarded burst
    write_mode(1'b1);
    chk(dma_mode, "R7", dma_mode, 1);
    chk(!end_of_dma, "R7", end_of_dma, 0);
    mon_auto = 1'b1;
    pulse_start();
    send_byte(8'h3C, 1'b1, 1'b1);
    send_byte(8'h00, 1'b1, 1'b1);
    send_byte(8'hFF, 1'b1, 1'b1);
    send_byte(8'h5A, 1'b1, 1'b1);
    send_byte(8'h81, 1'b1, 1'b1);
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) tick(1);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
    tick(2);
    mon_auto = 1'b0;

    // R5 BSY loss with DRQ pending
    send_byte(8'hC3, 1'b1, 1'b0);
    bus_bsy = 1'b0; tick(3);
    chk(!dma_mode, "R5", dma_mode, 0);
    chk(end_of_dma, "R5", end_of_dma, 1);
    chk(!drq, "R5", drq, 0);

    // R7 re-enter clears end flag; R5 phase mismatch
    bus_bsy = 1'b1; tick(3);
    write_mode(1'b1);
    chk(!end_of_dma, "R7", end_of_dma, 0);
    chk(dma_mode, "R7", dma_mode, 1);
    bus_msg = 1'b1; tick(3);
    chk(dma_mode, "R5", dma_mode, 1);
    tick(1);
    chk(!dma_mode, "R5", dma_mode, 0);
    chk(end_of_dma, "R5", end_of_dma, 1);
    bus_msg = 1'b0; tick(4);
    chk(phase_match, "R4", phase_match, 1);
    write_mode(1'b1);
    write_mode(1'b0);
    chk(!dma_mode, "R7", dma_mode, 0);

    // R8 soft reset mid-handshake with end flag set
    write_mode(1'b1);
    bus_bsy = 1'b0; tick(4);
    chk(end_of_dma, "R5", end_of_dma, 1);
    bus_bsy = 1'b1; tick(3);
    write_mode(1'b1);
    bus_bsy = 1'b0; tick(4);
    bus_bsy = 1'b1; tick(3);
    pulse_start();
    bus_data = 8'h77; bus_req = 1'b1; tick(3);
    chk(bus_ack, "R1", bus_ack, 1);
    soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    chk(!bus_ack, "R8", bus_ack, 0);
    chk(!drq, "R8", drq, 0);
    chk(!end_of_dma, "R8", end_of_dma, 0);
    chk(!dma_mode, "R8", dma_mode, 0);
    tick(8);
    chk(!bus_ack, "R8", bus_ack, 0);
    bus_req = 1'b0; tick(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule